// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a 16-bit processor whose datapath shares one memory and one ALU across several clock cycles per instruction. It steps through a small set of states for each instruction. In every state it drives the enables and multiplexer selects of the datapath: the program counter and instruction register load enables, the memory address source and write enable, the register-file write enable with its destination and data selects, the two ALU operand selects, the ALU function, and the next-PC select. Each instruction class takes its own short route back to the fetch state.

The 4-bit opcode comes from the datapath's instruction register and is valid from the decode state onward. For conditional branches the block takes two comparison flags from the datapath's ALU, equality and signed less-than of the two register operands. It resolves all six branch conditions itself and lets the PC load only when the selected condition holds.

An asynchronous active-low reset silences every write enable at once. The release passes through a synchronizer, and sequencing resumes in the fetch state.

Top module: `mcc_ctrl`

## Requirements
- R1: While `rst_n` is low, all write enables (`pc_wr`, `ir_wr`, `mem_wr`, `reg_wr`) are 0, including when reset arrives in the middle of an instruction. After release they stay 0 for one more rising edge, and the fetch state appears after the second rising edge.
- R2: Fetch asserts `pc_wr` and `ir_wr` and drives `alu_src_a`=0, `alu_src_b`=01, `pc_src`=00, `iord`=0, `alu_op`=000 (add).
- R3: Decode, the second cycle of every instruction, asserts no write enable and drives `alu_src_a`=0, `alu_src_b`=10, `alu_op`=000. The hold opcode returns from decode straight to fetch, two cycles in all.
- R4: Register-type add, sub, AND and OR take four cycles. The execute cycle drives `alu_src_a`=1, `alu_src_b`=00 and `alu_op` 000/001/010/011 respectively. The write-back cycle asserts `reg_wr` with `reg_dst`=01 and `mem_to_reg`=00.
- R5: A load takes five cycles. The address cycle drives `alu_src_a`=1 and `alu_src_b`=10. The read cycle drives `iord`=1 with `mem_wr`=0. The write-back cycle asserts `reg_wr` with `reg_dst`=00 and `mem_to_reg`=01.
- R6: A store takes four cycles: the same address cycle, then a cycle with `iord`=1 and `mem_wr`=1. `mem_wr` is asserted in no other cycle.
- R7: Add-immediate takes four cycles: the address cycle, then `reg_wr` with `reg_dst`=00 and `mem_to_reg`=00.
- R8: The branch condition is derived from `cmp_zero` (operands equal) and `cmp_neg` (first operand less than second). Equal: zero. Not-equal: not zero. Less: neg. Less-or-equal: neg or zero. Greater: neither. Greater-or-equal: not neg.
- R9: A branch takes three cycles. Its decision cycle drives `alu_src_a`=1, `alu_src_b`=00, `alu_op`=001 and `pc_src`=01, and `pc_wr` equals the condition.
- R10: A jump takes three cycles. Its last cycle asserts `pc_wr` with `pc_src`=10 and no register write.
- R11: Jump-and-return behaves as a jump and, in the same cycle, asserts `reg_wr` with `reg_dst`=10 (link register) and `mem_to_reg`=10 (PC value).
- R12: Opcode map: 0 hold, 1 add, 2 sub, 3 AND, 4 OR, 5 load, 6 store, 7 add-immediate, 8 branch-equal, 9 not-equal, A less, B less-or-equal, C greater, D greater-or-equal, E jump, F jump-and-return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Opcode field from the instruction register |
| cmp_zero | input | 1 | ALU result of operand compare is zero |
| cmp_neg | input | 1 | First operand is less than the second (signed) |
| pc_wr | output | 1 | Program counter load enable |
| iord | output | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_wr | output | 1 | Memory write enable |
| ir_wr | output | 1 | Instruction register load enable |
| reg_wr | output | 1 | Register file write enable |
| reg_dst | output | 2 | Destination: 00 rt field, 01 rd field, 10 link register |
| mem_to_reg | output | 2 | Write data: 00 ALU result register, 01 memory data register, 10 PC |
| alu_src_a | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU operand B: 00 register B, 01 constant one, 10 immediate |
| pc_src | output | 2 | Next PC: 00 ALU output, 01 ALU result register, 10 absolute target |
| alu_op | output | 3 | ALU function: 000 add, 001 sub, 010 AND, 011 OR |

## Verification
All control outputs decode the current state directly, so each cycle's controls are visible in the same clock period. The bench samples them on the falling edge after the state register advances. From the cycle in which `ir_wr` marks a fetch, the k-th following falling edge shows step k of that instruction. The instruction's length is the number of edges until `ir_wr` returns: 2, 3, 4 or 5 depending on the class. For reset, quiet enables are expected immediately on assertion, one further quiet edge after release, and the fetch pattern on the second edge.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OP_W     = 4;
  localparam int ALUOP_W  = 3;
  localparam int SRCB_W   = 2;
  localparam int PCSRC_W  = 2;
  localparam int DST_W    = 2;
  localparam int WBSEL_W  = 2;

  // opcode assignment
  localparam logic [OP_W-1:0] OP_HOLD = 4'h0;
  localparam logic [OP_W-1:0] OP_ADD  = 4'h1;
  localparam logic [OP_W-1:0] OP_SUB  = 4'h2;
  localparam logic [OP_W-1:0] OP_AND  = 4'h3;
  localparam logic [OP_W-1:0] OP_OR   = 4'h4;
  localparam logic [OP_W-1:0] OP_LW   = 4'h5;
  localparam logic [OP_W-1:0] OP_SW   = 4'h6;
  localparam logic [OP_W-1:0] OP_ADDI = 4'h7;
  localparam logic [OP_W-1:0] OP_BEQ  = 4'h8;
  localparam logic [OP_W-1:0] OP_BNE  = 4'h9;
  localparam logic [OP_W-1:0] OP_BLT  = 4'hA;
  localparam logic [OP_W-1:0] OP_BLE  = 4'hB;
  localparam logic [OP_W-1:0] OP_BGT  = 4'hC;
  localparam logic [OP_W-1:0] OP_BGE  = 4'hD;
  localparam logic [OP_W-1:0] OP_JMP  = 4'hE;
  localparam logic [OP_W-1:0] OP_JAL  = 4'hF;

  localparam logic [ALUOP_W-1:0] ALU_ADD = 3'd0;
  localparam logic [ALUOP_W-1:0] ALU_SUB = 3'd1;
  localparam logic [ALUOP_W-1:0] ALU_AND = 3'd2;
  localparam logic [ALUOP_W-1:0] ALU_OR  = 3'd3;

  localparam logic [SRCB_W-1:0]  SRCB_REG = 2'b00;
  localparam logic [SRCB_W-1:0]  SRCB_ONE = 2'b01;
  localparam logic [SRCB_W-1:0]  SRCB_IMM = 2'b10;

  localparam logic [PCSRC_W-1:0] PCSRC_ALU    = 2'b00;
  localparam logic [PCSRC_W-1:0] PCSRC_ALUREG = 2'b01;
  localparam logic [PCSRC_W-1:0] PCSRC_ABS    = 2'b10;

  localparam logic [DST_W-1:0]   DST_RT   = 2'b00;
  localparam logic [DST_W-1:0]   DST_RD   = 2'b01;
  localparam logic [DST_W-1:0]   DST_LINK = 2'b10;

  localparam logic [WBSEL_W-1:0] WB_ALU = 2'b00;
  localparam logic [WBSEL_W-1:0] WB_MDR = 2'b01;
  localparam logic [WBSEL_W-1:0] WB_PC  = 2'b10;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_MADDR,
    ST_MREAD,
    ST_LDWB,
    ST_MWRITE,
    ST_REXEC,
    ST_RWB,
    ST_AIWB,
    ST_BRANCH,
    ST_JUMP
  } state_e;

  typedef struct packed {
    logic                pc_wr;
    logic                iord;
    logic                mem_wr;
    logic                ir_wr;
    logic                reg_wr;
    logic [DST_W-1:0]    reg_dst;
    logic [WBSEL_W-1:0]  wb_sel;
    logic                src_a;
    logic [SRCB_W-1:0]   src_b;
    logic [PCSRC_W-1:0]  pc_src;
    logic [ALUOP_W-1:0]  alu_op;
  } ctl_t;

endpackage

// File: rtl/mcc_rst_sync.sv
module mcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign run = sync_q[STAGES-1];
endmodule

// File: rtl/mcc_branch_eval.sv
module mcc_branch_eval
  import mcc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic            cmp_zero,
  input  logic            cmp_neg,
  output logic            taken
);
  always_comb begin
    case (opcode)
      OP_BEQ:  taken = cmp_zero;
      OP_BNE:  taken = !cmp_zero;
      OP_BLT:  taken = cmp_neg;
      OP_BLE:  taken = cmp_neg || cmp_zero;
      OP_BGT:  taken = !cmp_neg && !cmp_zero;
      OP_BGE:  taken = !cmp_neg;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  state_e          cur,
  input  logic [OP_W-1:0] opcode,
  output state_e          nxt
);
  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH: nxt = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_HOLD:                        nxt = ST_FETCH;
          OP_ADD, OP_SUB, OP_AND, OP_OR:  nxt = ST_REXEC;
          OP_LW, OP_SW, OP_ADDI:          nxt = ST_MADDR;
          OP_JMP, OP_JAL:                 nxt = ST_JUMP;
          default:                        nxt = ST_BRANCH;
        endcase
      end
      ST_MADDR: begin
        case (opcode)
          OP_LW:   nxt = ST_MREAD;
          OP_SW:   nxt = ST_MWRITE;
          default: nxt = ST_AIWB;
        endcase
      end
      ST_MREAD: nxt = ST_LDWB;
      ST_REXEC: nxt = ST_RWB;
      default:  nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
  import mcc_pkg::*;
(
  input  state_e          cur,
  input  logic [OP_W-1:0] opcode,
  input  logic            taken,
  input  logic            run,
  output ctl_t            ctl
);
  logic [ALUOP_W-1:0] rtype_op;

  always_comb begin
    case (opcode)
      OP_SUB:  rtype_op = ALU_SUB;
      OP_AND:  rtype_op = ALU_AND;
      OP_OR:   rtype_op = ALU_OR;
      default: rtype_op = ALU_ADD;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    case (cur)
      ST_FETCH: begin
        ctl.pc_wr  = 1'b1;
        ctl.ir_wr  = 1'b1;
        ctl.src_b  = SRCB_ONE;
        ctl.pc_src = PCSRC_ALU;
      end
      ST_DECODE: begin
        ctl.src_b = SRCB_IMM;
      end
      ST_MADDR: begin
        ctl.src_a = 1'b1;
        ctl.src_b = SRCB_IMM;
      end
      ST_MREAD: begin
        ctl.iord = 1'b1;
      end
      ST_LDWB: begin
        ctl.reg_wr  = 1'b1;
        ctl.reg_dst = DST_RT;
        ctl.wb_sel  = WB_MDR;
      end
      ST_MWRITE: begin
        ctl.iord   = 1'b1;
        ctl.mem_wr = 1'b1;
      end
      ST_REXEC: begin
        ctl.src_a  = 1'b1;
        ctl.src_b  = SRCB_REG;
        ctl.alu_op = rtype_op;
      end
      ST_RWB: begin
        ctl.reg_wr  = 1'b1;
        ctl.reg_dst = DST_RD;
        ctl.wb_sel  = WB_ALU;
      end
      ST_AIWB: begin
        ctl.reg_wr  = 1'b1;
        ctl.reg_dst = DST_RT;
        ctl.wb_sel  = WB_ALU;
      end
      ST_BRANCH: begin
        ctl.src_a  = 1'b1;
        ctl.src_b  = SRCB_REG;
        ctl.alu_op = ALU_SUB;
        ctl.pc_src = PCSRC_ALUREG;
        ctl.pc_wr  = taken;
      end
      ST_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PCSRC_ABS;
        if (opcode == OP_JAL) begin
          ctl.reg_wr  = 1'b1;
          ctl.reg_dst = DST_LINK;
          ctl.wb_sel  = WB_PC;
        end
      end
      default: ;
    endcase
    if (!run) begin
      ctl.pc_wr  = 1'b0;
      ctl.ir_wr  = 1'b0;
      ctl.mem_wr = 1'b0;
      ctl.reg_wr = 1'b0;
    end
  end
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
  import mcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OP_W-1:0]     opcode,
  input  logic                cmp_zero,
  input  logic                cmp_neg,
  output logic                pc_wr,
  output logic                iord,
  output logic                mem_wr,
  output logic                ir_wr,
  output logic                reg_wr,
  output logic [DST_W-1:0]    reg_dst,
  output logic [WBSEL_W-1:0]  mem_to_reg,
  output logic                alu_src_a,
  output logic [SRCB_W-1:0]   alu_src_b,
  output logic [PCSRC_W-1:0]  pc_src,
  output logic [ALUOP_W-1:0]  alu_op
);
  logic   run;
  logic   taken;
  state_e state_q;
  state_e state_d;
  ctl_t   ctl;

  mcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  mcc_branch_eval u_branch_eval (
    .opcode   (opcode),
    .cmp_zero (cmp_zero),
    .cmp_neg  (cmp_neg),
    .taken    (taken)
  );

  mcc_next_state u_next_state (
    .cur    (state_q),
    .opcode (opcode),
    .nxt    (state_d)
  );

  // state register, advanced only once the reset release has synchronized
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
    end else if (run) begin
      state_q <= state_d;
    end
  end

  mcc_out_decode u_out_decode (
    .cur    (state_q),
    .opcode (opcode),
    .taken  (taken),
    .run    (run),
    .ctl    (ctl)
  );

  assign pc_wr      = ctl.pc_wr;
  assign iord       = ctl.iord;
  assign mem_wr     = ctl.mem_wr;
  assign ir_wr      = ctl.ir_wr;
  assign reg_wr     = ctl.reg_wr;
  assign reg_dst    = ctl.reg_dst;
  assign mem_to_reg = ctl.wb_sel;
  assign alu_src_a  = ctl.src_a;
  assign alu_src_b  = ctl.src_b;
  assign pc_src     = ctl.pc_src;
  assign alu_op     = ctl.alu_op;

  AST_FETCH_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> state_q == ST_FETCH); // R1
  AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state_q == ST_FETCH) |=> state_q == ST_DECODE); // R3
  AST_LOAD_WB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_LDWB |-> $past(state_q) == ST_MREAD); // R5
  AST_STORE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (iord && state_q == ST_MWRITE)); // R6
  AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, reg_wr, ir_wr})); // R6
  AST_BRANCH_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRANCH && !taken) |-> !pc_wr); // R9
  AST_SHORT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (state_q == ST_BRANCH || state_q == ST_JUMP)) |=> state_q == ST_FETCH); // R10
endmodule

// File: tb/test_mcc_ctrl.sv
`timescale 1ns/1ps
module test_mcc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] opcode;
  logic       cmp_zero, cmp_neg;
  logic       pc_wr, iord, mem_wr, ir_wr, reg_wr, alu_src_a;
  logic [1:0] reg_dst, mem_to_reg, alu_src_b, pc_src;
  logic [2:0] alu_op;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  mcc_ctrl i_mcc_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .cmp_zero(cmp_zero), .cmp_neg(cmp_neg),
    .pc_wr(pc_wr), .iord(iord), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_wr(reg_wr),
    .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .alu_src_a(alu_src_a),
    .alu_src_b(alu_src_b), .pc_src(pc_src), .alu_op(alu_op)
  );

  wire [16:0] got = {pc_wr, iord, mem_wr, ir_wr, reg_wr, reg_dst, mem_to_reg,
                     alu_src_a, alu_src_b, pc_src, alu_op};
  wire [3:0]  wen = {pc_wr, ir_wr, mem_wr, reg_wr};

  // stimulus: {opcode, cmp_zero, cmp_neg}
  localparam logic [5:0] VEC [25] = '{
    {4'h0,2'b00}, {4'h1,2'b00}, {4'h2,2'b00}, {4'h3,2'b00}, {4'h4,2'b00},
    {4'h5,2'b00}, {4'h6,2'b00}, {4'h7,2'b00}, {4'h8,2'b00}, {4'h9,2'b00},
    {4'hA,2'b00}, {4'hB,2'b00}, {4'hC,2'b00}, {4'hD,2'b00}, {4'hE,2'b00},
    {4'hF,2'b00}, {4'h8,2'b10}, {4'h9,2'b10}, {4'hA,2'b01}, {4'hB,2'b10},
    {4'hB,2'b01}, {4'hC,2'b10}, {4'hC,2'b01}, {4'hD,2'b01}, {4'hD,2'b10}
  };

  function automatic logic exp_taken(logic [3:0] op, logic z, logic n);
    case (op)
      4'h8: return z;          // R8 equal
      4'h9: return !z;
      4'hA: return n;
      4'hB: return n | z;
      4'hC: return !n && !z;
      4'hD: return !n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_len(logic [3:0] op);
    if (op == 4'h0) return 2;
    if (op == 4'h5) return 5;
    if (op >= 4'h8) return 3;
    return 4;
  endfunction

  function automatic string exp_tag(logic [3:0] op, int step);
    if (step == 0) return "R2";
    if (step == 1 || op == 4'h0) return "R3";
    if (op <= 4'h4) return "R4";
    if (op == 4'h5) return "R5";
    if (op == 4'h6) return "R6";
    if (op == 4'h7) return "R7";
    if (op <= 4'hD) return "R8/R9";
    if (op == 4'hE) return "R10";
    return "R11";
  endfunction

  function automatic logic [16:0] exp_ctl(logic [3:0] op, logic z, logic n, int step);
    logic pw = 0, io = 0, mw = 0, iw = 0, rw = 0, a = 0;
    logic [1:0] dst = 0, wb = 0, b = 0, ps = 0;
    logic [2:0] ao = 0;
    if (step == 0) begin
      pw = 1; iw = 1; b = 2'b01;
    end else if (step == 1) begin
      b = 2'b10;
    end else if (op >= 4'h1 && op <= 4'h4) begin
      if (step == 2) begin a = 1; ao = 3'(op - 4'h1); end
      else begin rw = 1; dst = 2'b01; end
    end else if (op >= 4'h5 && op <= 4'h7) begin
      if (step == 2) begin a = 1; b = 2'b10; end
      else if (op == 4'h5 && step == 3) io = 1;
      else if (op == 4'h5) begin rw = 1; wb = 2'b01; end
      else if (op == 4'h6) begin io = 1; mw = 1; end
      else rw = 1;
    end else if (op >= 4'h8 && op <= 4'hD) begin
      a = 1; ao = 3'd1; ps = 2'b01; pw = exp_taken(op, z, n);
    end else begin
      pw = 1; ps = 2'b10;
      if (op == 4'hF) begin rw = 1; dst = 2'b10; wb = 2'b10; end
    end
    return {pw, io, mw, iw, rw, dst, wb, a, b, ps, ao};
  endfunction

  task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_fetch();
    for (int k = 0; k < 10; k++) begin
      if (ir_wr === 1'b1) return;
      @(negedge clk);
    end
  endtask

  task automatic run_instr(logic [3:0] op, logic z, logic n);
    int len;
    wait_fetch();
    opcode = op; cmp_zero = z; cmp_neg = n;
    chk("R2 fetch", got, exp_ctl(op, z, n, 0));
    len = 0;
    for (int s = 1; s < 8; s++) begin
      @(negedge clk);
      if (ir_wr === 1'b1) begin len = s; break; end
      chk(exp_tag(op, s), got, exp_ctl(op, z, n, s));
    end
    chk({"R12 length ", exp_tag(op, 2)}, 17'(len), 17'(exp_len(op)));
  endtask

  task automatic check_release();
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 quiet after release", 17'(wen), 17'd0);
    @(negedge clk);
    chk("R1 fetch on second edge", got, exp_ctl(4'h0, 1'b0, 1'b0, 0));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; opcode = 4'h0; cmp_zero = 1'b0; cmp_neg = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 quiet in reset", 17'(wen), 17'd0);
    check_release();

    foreach (VEC[i]) run_instr(VEC[i][5:2], VEC[i][1], VEC[i][0]);

    // reset during the memory read of a load
    wait_fetch();
    opcode = 4'h5;
    repeat (3) @(negedge clk);
    chk("R5 read step before reset", got, exp_ctl(4'h5, 1'b0, 1'b0, 3));
    rst_n = 1'b0;
    #1;
    chk("R1 quiet on mid-instruction reset", 17'(wen), 17'd0);
    check_release();
    run_instr(4'h1, 1'b0, 1'b0);
    run_instr(4'hF, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule